// File: doc/BRIEF.md
# Pipeline Stall Hazard Detection Unit

This block lives in the decode stage of a five-stage, in-order pipeline. It finds read-after-write dependencies by comparing the two source register numbers of the decoding instruction with the destination numbers of the instructions now in execute, memory and writeback. Each of those three stages also presents a flag that says whether it will write its destination. When any live, nonzero destination matches either source, the unit freezes the program counter and the fetch/decode register. In the same cycle it turns the decode/execute control word into a bubble of all zeros.

The unit keeps no count of how long to stall. The producer moves one stage further each cycle, so the hazard goes from execute to memory to writeback and then clears. A producer found in execute therefore costs three bubbles, in memory two, and in writeback one. The only state in the block is the control field of the decode/execute register. It loads every cycle, either the decoded control word or the bubble.

Top module: `hdu_stall_unit`

## Requirements
- R1: When the execute stage's write flag is set and its destination is nonzero and equal to either source number, the stall asserts in the same cycle.
- R2: The same same-cycle rule applies to the memory stage's write flag and destination.
- R3: The same same-cycle rule applies to the writeback stage's write flag and destination.
- R4: A destination of register 0 never causes a stall, even when a source is also 0 and the write flag is set.
- R5: A stage whose write flag is clear never causes a stall, whatever its destination number is.
- R6: With no hazard, pc_wen and ir_wen are 1 and bubble_sel is 0. During a stall, pc_wen and ir_wen are 0 and bubble_sel is 1.
- R7: One clock edge after a cycle with bubble_sel=1, ex_ctrl is all zeros. After a cycle with bubble_sel=0, ex_ctrl equals the id_ctrl value present at that edge.
- R8: While rst_n is low, ex_ctrl is all zeros.
- R9: Several hazards at once, in different stages or on both sources, give the same single-cycle stall outputs as one hazard.
- R10: In a pipeline that advances normally, a consumer that directly follows its producer stalls for 3 cycles. With one independent instruction in between it stalls for 2 cycles, with two it stalls for 1, and with three it does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| id_src_a | input | REG_W | First source register number of the decoding instruction |
| id_src_b | input | REG_W | Second source register number of the decoding instruction |
| ex_wen | input | 1 | Execute-stage instruction will write a register |
| ex_dst | input | REG_W | Execute-stage destination register number |
| mem_wen | input | 1 | Memory-stage instruction will write a register |
| mem_dst | input | REG_W | Memory-stage destination register number |
| wb_wen | input | 1 | Writeback-stage instruction will write a register |
| wb_dst | input | REG_W | Writeback-stage destination register number |
| id_ctrl | input | CTRL_W | Control word decoded for the current instruction |
| pc_wen | output | 1 | Program counter update enable |
| ir_wen | output | 1 | Fetch/decode register update enable |
| bubble_sel | output | 1 | Selects a zero control word into the decode/execute register |
| ex_ctrl | output | CTRL_W | Registered control word now in the execute stage |

## Verification
The bench uses the default widths: REG_W=5 and CTRL_W=8. With these, every register number from 0 to 31 can be driven, so the zero-register exclusion and the highest register are both tested. An 8-bit control word lets an alternating pattern show a bubble on every bit. A small pipeline model in the bench feeds its own stage contents back into the unit. This is what makes the natural drain, of three, two, one and zero stall cycles, observable through the frozen program counter.

// File: rtl/hdu_pkg.sv
package hdu_pkg;
  // Index of each producer stage in the packed stage arrays.
  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } hdu_stage_e;

  localparam int unsigned HDU_NUM_STG = 3;
  localparam int unsigned HDU_NUM_SRC = 2;
endpackage

// File: rtl/hdu_stage_cmp.sv
module hdu_stage_cmp #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                            wen,
  input  logic [REG_W-1:0]                dst,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   src,
  output logic                            hit
);
  logic [NUM_SRC-1:0] eq;
  logic               dst_live;

  // One equality comparator per source number.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_eq
    assign eq[s] = (dst == src[s]);
  end

  assign dst_live = wen && (dst != '0);
  assign hit      = dst_live && (|eq);
endmodule

// File: rtl/hdu_ctrl_reg.sv
module hdu_ctrl_reg #(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bubble,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out
);
  // Decode/execute control field: it advances every cycle.
  localparam logic LOAD_EN = 1'b1;

  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (LOAD_EN) begin
      ctrl_d = bubble ? '0 : ctrl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_out = ctrl_q;
endmodule

// File: rtl/hdu_stall_unit.sv
module hdu_stall_unit
  import hdu_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  id_src_a,
  input  logic [REG_W-1:0]  id_src_b,
  input  logic              ex_wen,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              mem_wen,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              wb_wen,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic              pc_wen,
  output logic              ir_wen,
  output logic              bubble_sel,
  output logic [CTRL_W-1:0] ex_ctrl
);
  localparam int unsigned NSTG = HDU_NUM_STG;
  localparam int unsigned NSRC = HDU_NUM_SRC;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSTG-1:0]            stg_wen;
  logic [NSTG-1:0][REG_W-1:0] stg_dst;
  logic [NSTG-1:0]            stg_hit;
  logic                       stall;

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  assign stg_wen[STG_EX]  = ex_wen;
  assign stg_wen[STG_MEM] = mem_wen;
  assign stg_wen[STG_WB]  = wb_wen;
  assign stg_dst[STG_EX]  = ex_dst;
  assign stg_dst[STG_MEM] = mem_dst;
  assign stg_dst[STG_WB]  = wb_dst;

  // Three stages times two sources: six comparators in total.
  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    hdu_stage_cmp #(.REG_W(REG_W), .NUM_SRC(NSRC)) u_cmp (
      .wen (stg_wen[g]),
      .dst (stg_dst[g]),
      .src (srcs),
      .hit (stg_hit[g])
    );
  end

  assign stall      = |stg_hit;
  assign pc_wen     = ~stall;
  assign ir_wen     = ~stall;
  assign bubble_sel = stall;

  hdu_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bubble   (bubble_sel),
    .ctrl_in  (id_ctrl),
    .ctrl_out (ex_ctrl)
  );

  // Checks relating ports over time.
  p_ex_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wen && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b)) |-> bubble_sel);
  p_mem_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && mem_dst != '0 && (mem_dst == id_src_a || mem_dst == id_src_b)) |-> bubble_sel);
  p_wb_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_dst != '0 && (wb_dst == id_src_a || wb_dst == id_src_b)) |-> bubble_sel);
  p_zero_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0 && mem_dst == '0 && wb_dst == '0) |-> !bubble_sel);
  p_wen_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen && !mem_wen && !wb_wen) |-> (pc_wen && ir_wen));
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!pc_wen && !ir_wen));
  p_bubble_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> (ex_ctrl == '0));
  p_pass_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |=> (ex_ctrl == $past(id_ctrl)));
endmodule

// File: tb/hdu_stall_unit_tb.sv
module hdu_stall_unit_tb;
  localparam int REG_W  = 5;
  localparam int CTRL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  // Directed drive
  logic [REG_W-1:0] d_sa, d_sb, d_exd, d_memd, d_wbd;
  logic d_exw, d_memw, d_wbw;
  logic [CTRL_W-1:0] id_ctrl;
  logic use_mdl;

  // Pipeline model
  logic [REG_W-1:0] p_a [8];
  logic [REG_W-1:0] p_b [8];
  logic [REG_W-1:0] p_d [8];
  logic             p_w [8];
  logic mdl_clr;
  int   pc;
  logic [REG_W-1:0] ifid_a, ifid_b, idex_d, exmem_d, memwb_d;
  logic idex_w, exmem_w, memwb_w;

  logic [REG_W-1:0] sa, sb, exd, memd, wbd;
  logic exw, memw, wbw;
  logic pc_wen, ir_wen, bubble_sel;
  logic [CTRL_W-1:0] ex_ctrl;

  assign sa   = use_mdl ? ifid_a  : d_sa;
  assign sb   = use_mdl ? ifid_b  : d_sb;
  assign exd  = use_mdl ? idex_d  : d_exd;
  assign exw  = use_mdl ? idex_w  : d_exw;
  assign memd = use_mdl ? exmem_d : d_memd;
  assign memw = use_mdl ? exmem_w : d_memw;
  assign wbd  = use_mdl ? memwb_d : d_wbd;
  assign wbw  = use_mdl ? memwb_w : d_wbw;

  hdu_stall_unit #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(sa), .id_src_b(sb),
    .ex_wen(exw), .ex_dst(exd),
    .mem_wen(memw), .mem_dst(memd),
    .wb_wen(wbw), .wb_dst(wbd),
    .id_ctrl(id_ctrl),
    .pc_wen(pc_wen), .ir_wen(ir_wen), .bubble_sel(bubble_sel),
    .ex_ctrl(ex_ctrl)
  );

  // Fetch/decode holds its place while pc_wen is low, and the decode/execute
  // register takes a nop when bubble_sel is high.
  logic [REG_W-1:0] ifid_d;
  logic             ifid_w;
  always @(posedge clk) begin
    if (mdl_clr) begin
      pc <= 0;
      ifid_a <= '0; ifid_b <= '0; ifid_d <= '0; ifid_w <= 1'b0;
      idex_d <= '0; idex_w <= 1'b0;
      exmem_d <= '0; exmem_w <= 1'b0;
      memwb_d <= '0; memwb_w <= 1'b0;
    end else begin
      if (pc_wen) begin
        pc <= pc + 1;
        if (pc < 8) begin
          ifid_a <= p_a[pc]; ifid_b <= p_b[pc]; ifid_d <= p_d[pc]; ifid_w <= p_w[pc];
        end else begin
          ifid_a <= '0; ifid_b <= '0; ifid_d <= '0; ifid_w <= 1'b0;
        end
      end
      if (bubble_sel) begin
        idex_d <= '0; idex_w <= 1'b0;
      end else begin
        idex_d <= ifid_d; idex_w <= ifid_w;
      end
      exmem_d <= idex_d; exmem_w <= idex_w;
      memwb_d <= exmem_d; memwb_w <= exmem_w;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_dir();
    d_sa = '0; d_sb = '0; d_exd = '0; d_memd = '0; d_wbd = '0;
    d_exw = 1'b0; d_memw = 1'b0; d_wbw = 1'b0;
  endtask

  // Drive one combinational pattern at the negedge, then sample 1 ns later.
  task automatic apply(input logic [4:0] a, input logic [4:0] b,
                       input logic ew, input logic [4:0] ed,
                       input logic mw, input logic [4:0] md,
                       input logic ww, input logic [4:0] wd);
    @(negedge clk);
    d_sa = a; d_sb = b;
    d_exw = ew; d_exd = ed; d_memw = mw; d_memd = md; d_wbw = ww; d_wbd = wd;
    #1;
  endtask

  task automatic expect_stall(input bit exp, input string req);
    check(bubble_sel == exp, req, int'(bubble_sel), int'(exp));
    check(pc_wen == !exp && ir_wen == !exp, {req, " (R6 enables)"},
          int'({pc_wen, ir_wen}), exp ? 0 : 3);
  endtask

  task automatic t_reset();
    // R8: control field cleared during reset
    check(ex_ctrl == '0, "R8", int'(ex_ctrl), 0);
    #1;
    check(pc_wen && ir_wen && !bubble_sel, "R6 idle", int'({pc_wen, ir_wen, bubble_sel}), 6);
  endtask

  task automatic t_ex_hazard();
    apply(5'd7, 5'd3, 1, 5'd7, 0, 5'd0, 0, 5'd0); expect_stall(1, "R1 src a");
    apply(5'd2, 5'd31, 1, 5'd31, 0, 5'd0, 0, 5'd0); expect_stall(1, "R1 src b r31");
    apply(5'd2, 5'd4, 1, 5'd9, 0, 5'd0, 0, 5'd0); expect_stall(0, "R1 mismatch");
  endtask

  task automatic t_mem_hazard();
    apply(5'd12, 5'd1, 0, 5'd0, 1, 5'd12, 0, 5'd0); expect_stall(1, "R2 src a");
    apply(5'd1, 5'd12, 0, 5'd0, 1, 5'd12, 0, 5'd0); expect_stall(1, "R2 src b");
  endtask

  task automatic t_wb_hazard();
    apply(5'd20, 5'd5, 0, 5'd0, 0, 5'd0, 1, 5'd20); expect_stall(1, "R3 src a");
    apply(5'd6, 5'd20, 0, 5'd0, 0, 5'd0, 1, 5'd20); expect_stall(1, "R3 src b");
  endtask

  task automatic t_zero_dst();
    apply(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 1, 5'd0); expect_stall(0, "R4 all zero");
  endtask

  task automatic t_wen_off();
    apply(5'd8, 5'd9, 0, 5'd8, 0, 5'd9, 0, 5'd8); expect_stall(0, "R5 flags clear");
  endtask

  task automatic t_multi();
    apply(5'd4, 5'd4, 1, 5'd4, 1, 5'd4, 1, 5'd4); expect_stall(1, "R9 all stages");
    apply(5'd10, 5'd11, 1, 5'd11, 0, 5'd0, 1, 5'd10); expect_stall(1, "R9 ex+wb");
  endtask

  task automatic t_bubble_ctrl();
    // R7: a hazard turns the control word into zeros at the next edge
    apply(5'd3, 5'd0, 1, 5'd3, 0, 5'd0, 0, 5'd0);
    id_ctrl = 8'hA5;
    @(posedge clk); #1;
    check(ex_ctrl == '0, "R7 bubble", int'(ex_ctrl), 0);
    apply(5'd3, 5'd0, 0, 5'd0, 0, 5'd0, 0, 5'd0);
    id_ctrl = 8'h5A;
    @(posedge clk); #1;
    check(ex_ctrl == 8'h5A, "R7 pass", int'(ex_ctrl), 'h5A);
  endtask

  // R10: the producer writes r5, the consumer reads r5, separated by gap fillers
  task automatic t_distance(input int gap, input int exp_stalls);
    int stalls;
    @(negedge clk);
    clear_dir();
    for (int i = 0; i < 8; i++) begin
      p_a[i] = 5'd1; p_b[i] = 5'd2; p_d[i] = 5'd0; p_w[i] = 1'b0;
    end
    p_d[0] = 5'd5; p_w[0] = 1'b1;
    p_a[gap + 1] = 5'd5;
    use_mdl = 1'b1;
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
    stalls = 0;
    for (int c = 0; c < 12; c++) begin
      if (!pc_wen) stalls++;
      @(negedge clk);
    end
    check(stalls == exp_stalls, $sformatf("R10 gap %0d stalls", gap), stalls, exp_stalls);
    check(pc == 12 - exp_stalls, $sformatf("R10 gap %0d pc", gap), pc, 12 - exp_stalls);
    use_mdl = 1'b0;
    mdl_clr = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    use_mdl = 1'b0;
    mdl_clr = 1'b1;
    id_ctrl = 8'hFF;
    clear_dir();
    for (int i = 0; i < 8; i++) begin
      p_a[i] = '0; p_b[i] = '0; p_d[i] = '0; p_w[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_ex_hazard();
    t_mem_hazard();
    t_wb_hazard();
    t_zero_dst();
    t_wen_off();
    t_multi();
    t_bubble_ctrl();
    t_distance(0, 3);
    t_distance(1, 2);
    t_distance(2, 1);
    t_distance(3, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule